// File: doc/BRIEF.md
# Transmit Mailbox Scheduler

This block keeps three outgoing message slots for a bus controller and decides which one goes out next. Each slot holds an identifier word, a control word with a payload length and a 16-bit timestamp, and eight payload bytes. Software loads a slot through a simple word-wide write port and sets the slot's send request. The block then offers the winning slot to a frame engine over a valid/grant handshake. The engine later reports one of three outcomes: sent, arbitration lost, or error.

A runtime control bit picks the ordering rule. In one setting the smallest identifier goes first. In the other setting slots go out in the order their requests arrived. Per-slot flags record completion, success, arbitration loss and error. A status word shows which slots are empty, the lowest-numbered empty slot, and which pending slot would go out last. Software can cancel a slot, and an option turns off automatic retry after a failed attempt.

Top module: `tmb_sched`

## Requirements
- R1: After reset no slot is pending, `eng_valid` is low, the control word reads 0 and the status word reads 0x0070_0000 (all three empty flags set, every other field 0).
- R2: Writing the identifier word (group m+1, offset 0) of an empty slot with bit 0 set makes that slot pending. While a slot is pending, writes to any of its four words are ignored and its words read back unchanged. The identifier word reads back with bit 0 showing the pending state.
- R3: With control bit 0 clear, the slot offered is the pending slot whose identifier word bits 31:1 (standard id in 31:21, extended bits 20:3, id-type bit 2, frame-type bit 1), compared as an unsigned number, are smallest. Equal keys go to the lower slot number.
- R4: With control bit 0 set, pending slots are offered in the order their send requests were written.
- R5: `eng_valid` is high exactly when no attempt is in flight and some slot is pending. A grant starts the attempt. A sent outcome sets the slot's done flag (status bit m) and ok flag (bit 4+m) and empties the slot.
- R6: With control bit 1 clear, an arbitration-lost or error outcome sets the slot's lost flag (bit 8+m) or error flag (bit 12+m). The slot stays pending and is offered again.
- R7: With control bit 1 set, a lost or error outcome completes the slot: done is 1, ok is 0, and the slot is empty and not offered again.
- R8: Writing 1 to status bit m clears that done flag. If a completion for the same slot lands in the same cycle, the flag stays set.
- R9: Writing 1 to status bit 16+m for a pending slot that has not been granted empties it on the next cycle, with done set and ok clear.
- R10: Cancelling the slot in flight holds status bit 16+m at 1 until the outcome. A sent outcome then completes with ok set. A lost or error outcome completes with ok clear and no retry.
- R11: Status bits 22:20 are per-slot empty flags and bits 29:28 name the lowest-numbered empty slot. With all slots pending, both fields read 0.
- R12: Status bits 26:24 flag the single pending slot that the current rule would offer last, and only when two or more slots are pending. Otherwise they are 0.
- R13: At grant the engine sees the slot's identifier word, its length capped at 8 (length field is control-word bits 3:0, timestamp is bits 31:16), and payload {high word, low word}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address: bits 3:2 group (0 control/status, m+1 slot m), bits 1:0 offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address, same map |
| rd_data | output | 32 | Read data, combinational |
| eng_valid | output | 1 | A slot is offered to the frame engine |
| eng_mb | output | 2 | Number of the offered slot |
| eng_id | output | 32 | Identifier word of the offered slot |
| eng_len | output | 4 | Payload length, capped at 8 |
| eng_data | output | 64 | Payload bytes, high word above low word |
| eng_grant | input | 1 | Engine takes the offered slot |
| eng_done | input | 1 | Attempt in flight was sent |
| eng_lost | input | 1 | Attempt in flight lost arbitration |
| eng_err | input | 1 | Attempt in flight failed with an error |

## Verification
Two things can collide in one cycle. One is a software write-1 that clears a slot's done flag. The other is the engine's completion for that same slot, which sets the flag. The bench holds a slot in flight, then drives `eng_done` and the status write on the same clock edge. It then reads the status word: the done flag must still be 1, and a later lone clear must bring it to 0. A scoreboard queue holds the slot number, identifier, capped length and payload expected at each grant. The monitor compares these against the engine outputs, which judges both ordering rules, the tie rule and the retry path.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
    // Number of transmit slots; the status layout reserves 4 bits per field.
    localparam int MB_COUNT = 3;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 4;
    localparam int TS_W     = 16;
    localparam int MAX_LEN  = 8;
    localparam int KEY_W    = 31;

    // Word offsets inside an address group
    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd1;
    localparam logic [1:0] OFF_ID   = 2'd0;
    localparam logic [1:0] OFF_CTL  = 2'd1;
    localparam logic [1:0] OFF_DLO  = 2'd2;
    localparam logic [1:0] OFF_DHI  = 2'd3;

    // Status word field bases (slot m uses base + m)
    localparam int ST_DONE  = 0;
    localparam int ST_OK    = 4;
    localparam int ST_LOST  = 8;
    localparam int ST_ERR   = 12;
    localparam int ST_CXL   = 16;
    localparam int ST_EMPTY = 20;
    localparam int ST_LOWP  = 24;
    localparam int ST_NEXT  = 28;

    // Control word bits
    localparam int CT_BYREQ   = 0;
    localparam int CT_NORETRY = 1;

    // Priority key: standard id, extended bits, id type, frame type
    function automatic logic [KEY_W-1:0] prio_key(input logic [WORD_W-1:0] idw);
        return {idw[31:21], idw[20:3], idw[2], idw[1]};
    endfunction
endpackage

// File: rtl/tmb_slot.sv
// One transmit slot: stores identifier, length, timestamp and payload,
// tracks pending state and the per-slot outcome flags.
// Assumes ev_* arrive only while this slot is in flight and at most one
// of them is high per cycle.
module tmb_slot
    import tmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_id,
    input  logic              wr_ctl,
    input  logic              wr_dlo,
    input  logic              wr_dhi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr_done,
    input  logic              cxl_req,
    input  logic              inflight,
    input  logic              ev_done,
    input  logic              ev_lost,
    input  logic              ev_err,
    input  logic              no_retry,
    output logic [WORD_W-1:0] id_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [TS_W-1:0]   ts_q,
    output logic [WORD_W-1:0] dlo_q,
    output logic [WORD_W-1:0] dhi_q,
    output logic              pend,
    output logic              fin,
    output logic              ok,
    output logic              lost,
    output logic              err,
    output logic              cxl_wait,
    output logic              new_req
);
    logic fail_close;

    // A request is taken only by an empty slot
    assign new_req    = wr_id && !pend && wdata[0];
    assign fail_close = (ev_lost || ev_err) && (no_retry || cxl_wait || cxl_req);

    // Content registers: writable only while the slot is empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            len_q <= '0;
            ts_q  <= '0;
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (!pend) begin
            if (wr_id)  id_q  <= wdata;
            if (wr_ctl) begin
                len_q <= wdata[LEN_W-1:0];
                ts_q  <= wdata[WORD_W-1 -: TS_W];
            end
            if (wr_dlo) dlo_q <= wdata;
            if (wr_dhi) dhi_q <= wdata;
        end
    end

    // State and flags; later statements take precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            fin      <= 1'b0;
            ok       <= 1'b0;
            lost     <= 1'b0;
            err      <= 1'b0;
            cxl_wait <= 1'b0;
        end else begin
            if (new_req) begin
                pend <= 1'b1;
                ok   <= 1'b0;
                lost <= 1'b0;
                err  <= 1'b0;
            end
            if (clr_done) fin <= 1'b0;
            if (cxl_req && pend && !inflight) begin
                pend <= 1'b0;
                fin  <= 1'b1;
                ok   <= 1'b0;
            end
            if (cxl_req && pend && inflight) cxl_wait <= 1'b1;
            if (ev_lost) lost <= 1'b1;
            if (ev_err)  err  <= 1'b1;
            if (fail_close) begin
                pend     <= 1'b0;
                fin      <= 1'b1;
                ok       <= 1'b0;
                cxl_wait <= 1'b0;
            end
            if (ev_done) begin
                pend     <= 1'b0;
                fin      <= 1'b1;
                ok       <= 1'b1;
                cxl_wait <= 1'b0;
            end
        end
    end

    // R5
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> (fin && ok && !pend));
    // R9
    cxl_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cxl_req && pend && !inflight) |=> (!pend && fin && !ok));
    // R10
    cxl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cxl_wait && !ev_done && !ev_lost && !ev_err) |=> pend);
endmodule

// File: rtl/tmb_order.sv
// Ordering logic: keeps a request-age matrix and, under the selected rule,
// picks the pending slot to offer next and the one that would go last.
// Assumes at most one new request per cycle.
module tmb_order
    import tmb_pkg::*;
#(
    parameter int N  = MB_COUNT,
    parameter int KW = KEY_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          pend,
    input  logic [N-1:0]          new_req,
    input  logic [N-1:0][KW-1:0]  keys,
    input  logic                  by_req,
    output logic [N-1:0]          pick_oh,
    output logic                  pick_any,
    output logic [N-1:0]          lowp
);
    logic [N-1:0][N-1:0] older;   // older[i][j]: i requested before j
    logic [N-1:0][N-1:0] beats;   // beats[i][j]: i goes before j
    logic                multi;

    // Age matrix update: a new request becomes the youngest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i == j)          older[i][j] <= 1'b0;
                    else if (new_req[i]) older[i][j] <= 1'b0;
                    else if (new_req[j]) older[i][j] <= 1'b1;
                end
            end
        end
    end

    // Pairwise precedence under the active rule
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (by_req) beats[i][j] = older[i][j];
                else        beats[i][j] = (keys[i] < keys[j]) ||
                                          ((keys[i] == keys[j]) && (i < j));
            end
        end
    end

    // Winner and last-in-line selection
    always_comb begin
        multi = ($countones(pend) > 1);
        for (int i = 0; i < N; i++) begin
            pick_oh[i] = pend[i];
            lowp[i]    = pend[i] && multi;
            for (int j = 0; j < N; j++) begin
                if (j != i && pend[j]) begin
                    pick_oh[i] = pick_oh[i] && beats[i][j];
                    lowp[i]    = lowp[i] && beats[j][i];
                end
            end
        end
        pick_any = |pick_oh;
    end

    // R3
    pick_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh) && ((pend != '0) == pick_any));
    // R12
    lowp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lowp) && ((lowp & pick_oh) == '0));
endmodule

// File: rtl/tmb_sched.sv
// Transmit slot scheduler top: register decode and readback, slot
// instances, ordering logic and the frame-engine handshake.
// Assumes the engine raises exactly one outcome per granted attempt;
// if several are high, sent beats lost beats error.
module tmb_sched
    import tmb_pkg::*;
#(
    parameter int N = MB_COUNT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2+$clog2(N+1)-1:0]      wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [2+$clog2(N+1)-1:0]      rd_addr,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          eng_valid,
    output logic [$clog2(N)-1:0]          eng_mb,
    output logic [WORD_W-1:0]             eng_id,
    output logic [LEN_W-1:0]              eng_len,
    output logic [2*WORD_W-1:0]           eng_data,
    input  logic                          eng_grant,
    input  logic                          eng_done,
    input  logic                          eng_lost,
    input  logic                          eng_err
);
    localparam int MBW    = $clog2(N);
    localparam int GW     = $clog2(N+1);
    localparam int ADDR_W = 2 + GW;
    localparam int PADW   = WORD_W - TS_W - LEN_W;

    logic               by_req_q, no_retry_q, busy_q;
    logic [MBW-1:0]     cur_q, sel;
    logic               grant_now, stat_wr;
    logic [GW-1:0]      wgrp, rgrp;
    logic [1:0]         woff, roff;
    logic [N-1:0]       wr_id_v, wr_ctl_v, wr_dlo_v, wr_dhi_v;
    logic [N-1:0]       clr_done_v, cxl_req_v, inflight_v;
    logic [N-1:0]       ev_done_v, ev_lost_v, ev_err_v;
    logic [N-1:0]       pend_v, fin_v, ok_v, lost_v, err_v, cxl_wait_v, new_req_v;
    logic [N-1:0]       pick_oh, lowp;
    logic               pick_any;
    logic [N-1:0][WORD_W-1:0] id_v, dlo_v, dhi_v;
    logic [N-1:0][LEN_W-1:0]  len_v;
    logic [N-1:0][TS_W-1:0]   ts_v;
    logic [N-1:0][KEY_W-1:0]  keys;
    logic [WORD_W-1:0]  st_word;
    logic [MBW-1:0]     nxt_empty;

    assign wgrp = wr_addr[ADDR_W-1:2];
    assign woff = wr_addr[1:0];
    assign rgrp = rd_addr[ADDR_W-1:2];
    assign roff = rd_addr[1:0];
    assign stat_wr   = wr_en && (wgrp == '0) && (woff == OFF_STAT);
    assign eng_valid = !busy_q && pick_any;
    assign grant_now = eng_valid && eng_grant;

    // Write decode into per-slot strobes, clears and cancels
    always_comb begin
        for (int m = 0; m < N; m++) begin
            wr_id_v[m]    = wr_en && (wgrp == GW'(m+1)) && (woff == OFF_ID);
            wr_ctl_v[m]   = wr_en && (wgrp == GW'(m+1)) && (woff == OFF_CTL);
            wr_dlo_v[m]   = wr_en && (wgrp == GW'(m+1)) && (woff == OFF_DLO);
            wr_dhi_v[m]   = wr_en && (wgrp == GW'(m+1)) && (woff == OFF_DHI);
            clr_done_v[m] = stat_wr && wr_data[ST_DONE+m];
            cxl_req_v[m]  = stat_wr && wr_data[ST_CXL+m];
        end
    end

    // Route engine outcomes to the slot in flight
    always_comb begin
        for (int m = 0; m < N; m++) begin
            ev_done_v[m]  = busy_q && (cur_q == MBW'(m)) && eng_done;
            ev_lost_v[m]  = busy_q && (cur_q == MBW'(m)) && eng_lost && !eng_done;
            ev_err_v[m]   = busy_q && (cur_q == MBW'(m)) && eng_err && !eng_done && !eng_lost;
            inflight_v[m] = (busy_q && (cur_q == MBW'(m))) ||
                            (grant_now && (sel == MBW'(m)));
            keys[m]       = prio_key(id_v[m]);
        end
    end

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            by_req_q   <= 1'b0;
            no_retry_q <= 1'b0;
        end else if (wr_en && (wgrp == '0) && (woff == OFF_CTRL)) begin
            by_req_q   <= wr_data[CT_BYREQ];
            no_retry_q <= wr_data[CT_NORETRY];
        end
    end

    // Attempt-in-flight tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (grant_now) begin
            busy_q <= 1'b1;
            cur_q  <= sel;
        end else if (busy_q && (eng_done || eng_lost || eng_err)) begin
            busy_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        tmb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_id    (wr_id_v[g]),
            .wr_ctl   (wr_ctl_v[g]),
            .wr_dlo   (wr_dlo_v[g]),
            .wr_dhi   (wr_dhi_v[g]),
            .wdata    (wr_data),
            .clr_done (clr_done_v[g]),
            .cxl_req  (cxl_req_v[g]),
            .inflight (inflight_v[g]),
            .ev_done  (ev_done_v[g]),
            .ev_lost  (ev_lost_v[g]),
            .ev_err   (ev_err_v[g]),
            .no_retry (no_retry_q),
            .id_q     (id_v[g]),
            .len_q    (len_v[g]),
            .ts_q     (ts_v[g]),
            .dlo_q    (dlo_v[g]),
            .dhi_q    (dhi_v[g]),
            .pend     (pend_v[g]),
            .fin      (fin_v[g]),
            .ok       (ok_v[g]),
            .lost     (lost_v[g]),
            .err      (err_v[g]),
            .cxl_wait (cxl_wait_v[g]),
            .new_req  (new_req_v[g])
        );
    end

    tmb_order #(.N(N), .KW(KEY_W)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_v),
        .new_req  (new_req_v),
        .keys     (keys),
        .by_req   (by_req_q),
        .pick_oh  (pick_oh),
        .pick_any (pick_any),
        .lowp     (lowp)
    );

    // Encode winner, find lowest empty slot, build the status word
    always_comb begin
        sel       = '0;
        nxt_empty = '0;
        for (int m = 0; m < N; m++)
            if (pick_oh[m]) sel = MBW'(m);
        for (int m = N-1; m >= 0; m--)
            if (!pend_v[m]) nxt_empty = MBW'(m);
        st_word = '0;
        for (int m = 0; m < N; m++) begin
            st_word[ST_DONE+m]  = fin_v[m];
            st_word[ST_OK+m]    = ok_v[m];
            st_word[ST_LOST+m]  = lost_v[m];
            st_word[ST_ERR+m]   = err_v[m];
            st_word[ST_CXL+m]   = cxl_wait_v[m];
            st_word[ST_EMPTY+m] = !pend_v[m];
            st_word[ST_LOWP+m]  = lowp[m];
        end
        st_word[ST_NEXT +: MBW] = nxt_empty;
    end

    // Engine-facing view of the selected slot
    always_comb begin
        eng_mb   = sel;
        eng_id   = id_v[sel];
        eng_len  = (len_v[sel] > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_v[sel];
        eng_data = {dhi_v[sel], dlo_v[sel]};
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rgrp == '0) begin
            if (roff == OFF_CTRL)      rd_data = {{(WORD_W-2){1'b0}}, no_retry_q, by_req_q};
            else if (roff == OFF_STAT) rd_data = st_word;
        end
        for (int m = 0; m < N; m++) begin
            if (rgrp == GW'(m+1)) begin
                case (roff)
                    OFF_ID:  rd_data = {id_v[m][WORD_W-1:1], pend_v[m]};
                    OFF_CTL: rd_data = {ts_v[m], {PADW{1'b0}}, len_v[m]};
                    OFF_DLO: rd_data = dlo_v[m];
                    default: rd_data = dhi_v[m];
                endcase
            end
        end
    end

    // R5
    valid_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> pend_v[eng_mb]);
    // R6
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (eng_lost || eng_err) && !eng_done && !no_retry_q &&
         (cxl_wait_v == '0) && !stat_wr) |=> pend_v[$past(cur_q)]);
    // R7
    no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (eng_lost || eng_err) && !eng_done && no_retry_q)
        |=> !pend_v[$past(cur_q)]);
endmodule

// File: tb/sim_tmb_sched.sv
module sim_tmb_sched;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_valid;
    logic [1:0]  eng_mb;
    logic [31:0] eng_id;
    logic [3:0]  eng_len;
    logic [63:0] eng_data;
    logic        eng_grant = 1'b0, eng_done = 1'b0, eng_lost = 1'b0, eng_err = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0]  q_mb[$];
    logic [31:0] q_id[$];
    logic [3:0]  q_len[$];
    logic [63:0] q_dat[$];
    string       q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    tmb_sched u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .eng_valid(eng_valid), .eng_mb(eng_mb),
        .eng_id(eng_id), .eng_len(eng_len), .eng_data(eng_data), .eng_grant(eng_grant),
        .eng_done(eng_done), .eng_lost(eng_lost), .eng_err(eng_err)
    );

    function automatic logic [31:0] mkid(input logic [10:0] s, input logic [17:0] e,
                                         input logic ide, input logic rtr);
        return {s, e, ide, rtr, 1'b1};
    endfunction

    function automatic logic [3:0] adr(input int m, input int off);
        return 4'((m + 1) * 4 + off);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic load(input int m, input logic [31:0] id, input logic [31:0] ctl,
                        input logic [31:0] lo, input logic [31:0] hi);
        wr(adr(m, 1), ctl);
        wr(adr(m, 2), lo);
        wr(adr(m, 3), hi);
        wr(adr(m, 0), id);
    endtask

    // Driver side of the scoreboard
    task automatic expect_tx(input string tag, input int m, input logic [31:0] id,
                             input logic [3:0] len, input logic [63:0] dat);
        q_tag.push_back(tag);
        q_mb.push_back(2'(m));
        q_id.push_back(id);
        q_len.push_back(len);
        q_dat.push_back(dat);
    endtask

    task automatic grant_only();
        for (int w = 0; w < 20 && !eng_valid; w++) begin
            @(posedge clk); #1;
        end
        if (!eng_valid) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 eng_valid actual=0 expected=1");
        end
        eng_grant = 1'b1;
        @(posedge clk); #1;
        eng_grant = 1'b0;
    endtask

    task automatic outcome(input int kind);
        eng_done = (kind == 0);
        eng_lost = (kind == 1);
        eng_err  = (kind == 2);
        @(posedge clk); #1;
        eng_done = 1'b0; eng_lost = 1'b0; eng_err = 1'b0;
    endtask

    task automatic serve(input int kind);
        grant_only();
        outcome(kind);
    endtask

    // Monitor side of the scoreboard: compare every grant
    always @(negedge clk) begin
        if (rst_n && eng_valid && eng_grant) begin
            if (q_mb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5 unexpected grant actual=%0d expected=none", eng_mb);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " slot"}, 64'(eng_mb), 64'(q_mb.pop_front()));
                check({t, " id"}, 64'(eng_id), 64'(q_id.pop_front()));
                check({t, " R13 len"}, 64'(eng_len), 64'(q_len.pop_front()));
                check({t, " R13 data"}, eng_data, q_dat.pop_front());
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] st, v;
        logic [31:0] id0, id1, id2;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(4'd1, st);
        check("R1 status", 64'(st), 64'h0070_0000);
        rd(4'd0, v);
        check("R1 control", 64'(v), 64'h0);
        check("R1 eng_valid", 64'(eng_valid), 64'h0);

        // R3 smallest key first, tie to lower slot; R13 length cap
        id0 = mkid(11'h300, 18'h0, 1'b0, 1'b0);
        id1 = mkid(11'h100, 18'h0, 1'b0, 1'b0);
        id2 = mkid(11'h100, 18'h0, 1'b0, 1'b0);
        load(0, id0, 32'h1234_0005, 32'hA0A1A2A3, 32'hA4A5A6A7);
        load(1, id1, 32'h0000_000C, 32'hB0B1B2B3, 32'hB4B5B6B7);
        load(2, id2, 32'h0000_0008, 32'hC0C1C2C3, 32'hC4C5C6C7);
        // R2 pending and write ignore
        rd(adr(0, 0), v);
        check("R2 id pending", 64'(v), 64'(id0));
        wr(adr(0, 0), 32'hFFFF_FFFF);
        wr(adr(0, 1), 32'h0);
        rd(adr(0, 0), v);
        check("R2 id ignored", 64'(v), 64'(id0));
        rd(adr(0, 1), v);
        check("R2 ctl ignored", 64'(v), 64'h1234_0005);
        // R11 all full, R12 last in line is slot 0
        rd(4'd1, st);
        check("R11 R12 status full", 64'(st), 64'h0100_0000);
        expect_tx("R3 first", 1, id1, 4'd8, 64'hB4B5B6B7_B0B1B2B3);
        expect_tx("R3 tie", 2, id2, 4'd8, 64'hC4C5C6C7_C0C1C2C3);
        expect_tx("R3 last", 0, id0, 4'd5, 64'hA4A5A6A7_A0A1A2A3);
        serve(0); serve(0); serve(0);
        rd(4'd1, st);
        check("R5 status after sends", 64'(st), 64'h0070_0077);
        check("R5 idle", 64'(eng_valid), 64'h0);

        // R8 plain clear
        wr(4'd1, 32'h5);
        rd(4'd1, st);
        check("R8 clear", 64'(st), 64'h0070_0072);
        wr(4'd1, 32'h2);

        // R3 extended bits decide; R11 next empty; R12 two pending
        id0 = mkid(11'h050, 18'h5, 1'b1, 1'b0);
        id1 = mkid(11'h050, 18'h2, 1'b1, 1'b0);
        load(0, id0, 32'h4, 32'h1, 32'h2);
        load(1, id1, 32'h3, 32'h3, 32'h4);
        rd(4'd1, st);
        check("R11 R12 status two pending", 64'(st), 64'h2140_0040);
        expect_tx("R3 ext first", 1, id1, 4'd3, 64'h00000004_00000003);
        expect_tx("R3 ext second", 0, id0, 4'd4, 64'h00000002_00000001);
        serve(0); serve(0);

        // R4 request order
        wr(4'd0, 32'h1);
        id2 = mkid(11'h700, 18'h0, 1'b0, 1'b0);
        id0 = mkid(11'h010, 18'h0, 1'b0, 1'b0);
        id1 = mkid(11'h001, 18'h0, 1'b0, 1'b0);
        load(2, id2, 32'h1, 32'h22, 32'h0);
        load(0, id0, 32'h1, 32'h00, 32'h0);
        load(1, id1, 32'h1, 32'h11, 32'h0);
        rd(4'd1, st);
        check("R12 last by request", 64'((st >> 24) & 32'h7), 64'h2);
        expect_tx("R4 first", 2, id2, 4'd1, 64'h22);
        expect_tx("R4 second", 0, id0, 4'd1, 64'h00);
        expect_tx("R4 third", 1, id1, 4'd1, 64'h11);
        serve(0); serve(0); serve(0);

        // R6 retry after lost
        id0 = mkid(11'h123, 18'h0, 1'b0, 1'b1);
        load(0, id0, 32'h0, 32'h0, 32'h0);
        expect_tx("R6 try", 0, id0, 4'd0, 64'h0);
        expect_tx("R6 retry", 0, id0, 4'd0, 64'h0);
        serve(1);
        rd(4'd1, st);
        check("R6 lost flag", 64'((st >> 8) & 32'h1), 64'h1);
        rd(adr(0, 0), v);
        check("R6 still pending", 64'(v[0]), 64'h1);
        serve(0);
        rd(4'd1, st);
        check("R6 done after retry", 64'((st >> 4) & 32'h1), 64'h1);

        // R7 no retry on error
        wr(4'd0, 32'h3);
        wr(4'd1, 32'h7);
        id1 = mkid(11'h200, 18'h0, 1'b0, 1'b0);
        load(1, id1, 32'h2, 32'h5, 32'h6);
        expect_tx("R7 try", 1, id1, 4'd2, 64'h00000006_00000005);
        serve(2);
        rd(4'd1, st);
        check("R7 done", 64'((st >> 1) & 32'h1), 64'h1);
        check("R7 ok clear", 64'((st >> 5) & 32'h1), 64'h0);
        check("R7 err flag", 64'((st >> 13) & 32'h1), 64'h1);
        check("R7 no reoffer", 64'(eng_valid), 64'h0);

        // R9 cancel before grant
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h7);
        id2 = mkid(11'h0AA, 18'h0, 1'b0, 1'b0);
        load(2, id2, 32'h0, 32'h0, 32'h0);
        wr(4'd1, 32'h1 << 18);
        rd(adr(2, 0), v);
        check("R9 emptied", 64'(v[0]), 64'h0);
        rd(4'd1, st);
        check("R9 done ok", 64'((st >> 2) & 32'h11), 64'h1);
        check("R9 no offer", 64'(eng_valid), 64'h0);

        // R10 cancel in flight, then lost
        id0 = mkid(11'h011, 18'h0, 1'b0, 1'b0);
        load(0, id0, 32'h0, 32'h0, 32'h0);
        expect_tx("R10 lost try", 0, id0, 4'd0, 64'h0);
        grant_only();
        wr(4'd1, 32'h1 << 16);
        rd(4'd1, st);
        check("R10 cancel waiting", 64'((st >> 16) & 32'h1), 64'h1);
        rd(adr(0, 0), v);
        check("R10 still pending", 64'(v[0]), 64'h1);
        outcome(1);
        rd(4'd1, st);
        check("R10 lost closes", 64'({st[16], st[4], st[0]}), 64'h1);
        check("R10 no retry", 64'(eng_valid), 64'h0);

        // R10 cancel in flight, then sent
        id1 = mkid(11'h022, 18'h0, 1'b0, 1'b0);
        load(1, id1, 32'h0, 32'h0, 32'h0);
        expect_tx("R10 sent try", 1, id1, 4'd0, 64'h0);
        grant_only();
        wr(4'd1, 32'h1 << 17);
        outcome(0);
        rd(4'd1, st);
        check("R10 sent ok", 64'({st[17], st[5], st[1]}), 64'h3);

        // R8 completion and clear in the same cycle
        wr(4'd1, 32'h7);
        rd(4'd1, st);
        check("R8 all cleared", 64'(st & 32'h7), 64'h0);
        id2 = mkid(11'h033, 18'h0, 1'b0, 1'b0);
        load(2, id2, 32'h0, 32'h0, 32'h0);
        expect_tx("R8 try", 2, id2, 4'd0, 64'h0);
        grant_only();
        eng_done = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h4;
        @(posedge clk); #1;
        eng_done = 1'b0; wr_en = 1'b0;
        rd(4'd1, st);
        check("R8 set wins", 64'((st >> 2) & 32'h1), 64'h1);
        wr(4'd1, 32'h4);
        rd(4'd1, st);
        check("R8 later clear", 64'((st >> 2) & 32'h1), 64'h0);

        repeat (3) @(posedge clk); #1;
        check("R5 scoreboard drained", 64'(q_mb.size()), 64'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule